// File: doc/BRIEF.md
# Grouped GPIO Interrupt Summary and Request Line

This block sits between a bank of GPIO pins and the host interrupt controller. Each pin supplies a pending flag from detection logic outside this block. The flags are folded four pins at a time into one summary bit. The whole summary is read through a pair of 32-bit status words, of which only the low 46 bits carry groups; software reads these words to find which group of pins to service.

One interrupt request line goes to the host. The line gives a single-cycle pulse when something is pending and the block is armed. The block then stays quiet until software writes an end-of-interrupt command to the control word. If pins are still pending at that point, a new pulse follows at once. Otherwise the block waits, armed, for the next pending flag. Servicing pins one by one therefore never produces a storm of requests, and no pending pin goes unseen after the end-of-interrupt write.

Top module: `gsa_irq_aggregator`

## Requirements
- R1: Summary bit k is 1 exactly when any of pins 4k, 4k+1, 4k+2 or 4k+3 is pending. A read of the low status word (byte offset 0x0) returns summary bits 31:0 in the same cycle as the address.
- R2: A read of the high status word (byte offset 0x4) returns summary bits 63:32. With the default of 184 pins (46 groups), bits 31:14 of this word always read 0, and bit 13 reflects pins 180 to 183.
- R3: A read of the control word (byte offset 0x8) always returns 0, including right after an end-of-interrupt write. A read of any other offset also returns 0.
- R4: While armed, any pending pin causes irq_o to be high for exactly one cycle, starting at the clock edge after the flag is seen.
- R5: After a pulse, irq_o stays low for as long as no end-of-interrupt is written, whatever the pending flags do.
- R6: An end-of-interrupt is a write to offset 0x8 with data bit 0 set. The block re-arms at that write's clock edge. If any pin is pending, irq_o pulses at the following edge; otherwise the line waits until a pin becomes pending.
- R7: Writes to offsets 0x0 or 0x4, and writes to 0x8 with data bit 0 clear, change neither the read data nor irq_o.
- R8: While reset is asserted and right after it, irq_o is low and the block is armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| pend_i | input | NUM_PINS | Per-pin pending flags |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wen_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on address |
| irq_o | output | 1 | Interrupt request pulse to the host |

## Verification
The bench builds the block with its defaults: 184 pins, four pins per group and a 4-bit address. The 46 groups then fill the low status word and part of the high one. This brings the boundary between the two words (pins 127 and 128) within reach, along with the last valid group (pins 180 to 183) and the always-zero upper bits of the high word. Directed sequences step the request line through its pulse, quiet and re-arm phases, including re-arming with nothing pending. Random sparse pending patterns then exercise the folding of pins into groups across all 46 groups.

// File: rtl/gsa_pkg.sv
package gsa_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned SUM_W  = 2 * DATA_W;

  // word indices (byte offset / 4)
  localparam int unsigned WORD_SUM_LO = 0;
  localparam int unsigned WORD_SUM_HI = 1;
  localparam int unsigned WORD_CTRL   = 2;

  // end-of-interrupt command bit in the control word
  localparam int unsigned EOI_BIT = 0;

  typedef enum logic {
    ST_ARMED = 1'b0,
    ST_FIRED = 1'b1
  } irq_state_e;

endpackage

// File: rtl/gsa_group_or.sv
module gsa_group_or #(
  parameter int unsigned NUM_PINS       = 184,
  parameter int unsigned PINS_PER_GROUP = 4,
  parameter int unsigned GROUPS         = (NUM_PINS + PINS_PER_GROUP - 1) / PINS_PER_GROUP
) (
  input  logic [NUM_PINS-1:0] pend_i,
  output logic [GROUPS-1:0]   group_o
);

  localparam int unsigned PAD_W = GROUPS * PINS_PER_GROUP;

  logic [PAD_W-1:0] padded;

  // pins beyond NUM_PINS in a partial last group are tied to zero
  assign padded = PAD_W'(pend_i);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign group_o[g] = |padded[g*PINS_PER_GROUP +: PINS_PER_GROUP];
  end

endmodule

// File: rtl/gsa_regfile.sv
module gsa_regfile
  import gsa_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned GROUPS = 46
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wen_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [GROUPS-1:0] group_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              eoi_o
);

  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [SUM_W-1:0]  summary;

  assign word    = addr_i[ADDR_W-1:2];
  assign summary = SUM_W'(group_i);

  always_comb begin
    rdata_o = '0;
    unique case (word)
      WORD_W'(WORD_SUM_LO): rdata_o = summary[DATA_W-1:0];
      WORD_W'(WORD_SUM_HI): rdata_o = summary[SUM_W-1:DATA_W];
      default:              rdata_o = '0;
    endcase
  end

  // the command bit is not stored: it acts only in the cycle of the write
  assign eoi_o = wen_i && (word == WORD_W'(WORD_CTRL)) && wdata_i[EOI_BIT];

endmodule

// File: rtl/gsa_irq_ctrl.sv
module gsa_irq_ctrl
  import gsa_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_pend_i,
  input  logic eoi_i,
  output logic irq_o,
  output logic armed_o
);

  irq_state_e state_q, state_d;
  logic       irq_q, irq_d;

  always_comb begin
    state_d = state_q;
    irq_d   = 1'b0;
    unique case (state_q)
      ST_ARMED: begin
        if (any_pend_i) begin
          state_d = ST_FIRED;
          irq_d   = 1'b1;
        end
      end
      ST_FIRED: begin
        if (eoi_i) state_d = ST_ARMED;
      end
      default: state_d = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ARMED;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
    end
  end

  assign irq_o   = irq_q;
  assign armed_o = (state_q == ST_ARMED);

endmodule

// File: rtl/gsa_irq_aggregator.sv
module gsa_irq_aggregator
  import gsa_pkg::*;
#(
  parameter int unsigned NUM_PINS       = 184,
  parameter int unsigned PINS_PER_GROUP = 4,
  parameter int unsigned ADDR_W         = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pend_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_wen_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                irq_o
);

  localparam int unsigned GROUPS = (NUM_PINS + PINS_PER_GROUP - 1) / PINS_PER_GROUP;

  logic              rst_meta_q, rst_sync_n;
  logic [GROUPS-1:0] group_w;
  logic              eoi_w;
  logic              armed_w;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  gsa_group_or #(
    .NUM_PINS      (NUM_PINS),
    .PINS_PER_GROUP(PINS_PER_GROUP),
    .GROUPS        (GROUPS)
  ) u_group (
    .pend_i (pend_i),
    .group_o(group_w)
  );

  gsa_regfile #(
    .ADDR_W(ADDR_W),
    .GROUPS(GROUPS)
  ) u_regs (
    .addr_i (reg_addr_i),
    .wen_i  (reg_wen_i),
    .wdata_i(reg_wdata_i),
    .group_i(group_w),
    .rdata_o(reg_rdata_o),
    .eoi_o  (eoi_w)
  );

  gsa_irq_ctrl u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .any_pend_i(|group_w),
    .eoi_i     (eoi_w),
    .irq_o     (irq_o),
    .armed_o   (armed_w)
  );

endmodule

// File: rtl/gsa_irq_aggregator_chk.sv
module gsa_irq_aggregator_chk #(
  parameter int unsigned NUM_PINS = 184,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned GROUPS   = 46
) (
  input logic                clk_i,
  input logic                rst_sync_n,
  input logic [NUM_PINS-1:0] pend_i,
  input logic [ADDR_W-1:0]   reg_addr_i,
  input logic [31:0]         reg_rdata_o,
  input logic                irq_o,
  input logic                armed_w,
  input logic                eoi_w
);

  localparam int unsigned HI_VALID = (GROUPS > 32) ? (GROUPS - 32) : 0;

  // R4: armed with a pending pin -> request next cycle
  a_r4_fire_when_armed: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (armed_w && (|pend_i)) |=> irq_o);

  // R4: a request lasts a single cycle
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    irq_o |=> !irq_o);

  // R5: no end-of-interrupt while fired -> line stays low
  a_r5_quiet_until_eoi: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!armed_w && !eoi_w) |=> !irq_o);

  // R2: groups above the valid range read zero in the high word
  a_r2_high_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (reg_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(1)) |-> ((reg_rdata_o >> HI_VALID) == 32'd0));

  // R3: control word reads zero
  a_r3_ctrl_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (reg_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(2)) |-> (reg_rdata_o == 32'd0));

  // R8: no request while held in reset
  always_comb begin
    if (!rst_sync_n) a_r8_reset_quiet: assert (!irq_o || $isunknown(irq_o));
  end

endmodule

bind gsa_irq_aggregator gsa_irq_aggregator_chk #(
  .NUM_PINS(NUM_PINS),
  .ADDR_W  (ADDR_W),
  .GROUPS  (GROUPS)
) chk_i (
  .clk_i      (clk_i),
  .rst_sync_n (rst_sync_n),
  .pend_i     (pend_i),
  .reg_addr_i (reg_addr_i),
  .reg_rdata_o(reg_rdata_o),
  .irq_o      (irq_o),
  .armed_w    (armed_w),
  .eoi_w      (eoi_w)
);

// File: tb/gsa_irq_aggregator_tb.sv
module gsa_irq_aggregator_tb_top;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NPINS      = 184;
  localparam int unsigned AW         = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NPINS-1:0] pend;
  logic [AW-1:0]    addr;
  logic             wen;
  logic [31:0]      wdata;
  logic [31:0]      rdata;
  logic             irq;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  bit          done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gsa_irq_aggregator #(
    .NUM_PINS(NPINS), .PINS_PER_GROUP(4), .ADDR_W(AW)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .reg_addr_i(addr),
    .reg_wen_i(wen), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [63:0] exp_sum(input logic [NPINS-1:0] p);
    logic [63:0] s = '0;
    for (int i = 0; i < NPINS; i++) if (p[i]) s[i/4] = 1'b1;
    return s;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // one-cycle write; returns right after the write's edge
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wen = 1'b1;
    step();
    wen = 1'b0; wdata = '0;
  endtask

  task automatic summary_line();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary_line();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] e;
    void'($urandom(32'h5A17));
    rst_n = 1'b0; pend = '0; addr = '0; wen = 1'b0; wdata = '0;
    repeat (3) step();
    chk("R8 irq in reset", {63'd0, irq}, 64'd0);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R8 irq after reset", {63'd0, irq}, 64'd0);

    // R1 and R4: single pending pin while armed
    pend[2] = 1'b1;
    rd(4'h0, d);
    chk("R1 pin2 low word", {32'd0, d}, 64'd1);
    step();
    chk("R4 pulse high", {63'd0, irq}, 64'd1);
    step();
    chk("R4 pulse ends", {63'd0, irq}, 64'd0);
    // R5: more pins pend, line stays quiet
    pend[9] = 1'b1;
    repeat (5) step();
    chk("R5 quiet while fired", {63'd0, irq}, 64'd0);
    // R7: writes that do nothing
    wr(4'h0, 32'hFFFF_FFFF);
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h8, 32'hFFFF_FFFE);
    step();
    chk("R7 irq after ignored writes", {63'd0, irq}, 64'd0);
    rd(4'h0, d);
    chk("R7 low word unchanged", {32'd0, d}, 64'h5);
    rd(4'h4, d);
    chk("R7 high word unchanged", {32'd0, d}, 64'd0);
    // R6: end-of-interrupt with pins pending
    wr(4'h8, 32'h1);
    chk("R6 no pulse at eoi edge", {63'd0, irq}, 64'd0);
    step();
    chk("R6 pulse after eoi", {63'd0, irq}, 64'd1);
    rd(4'h8, d);
    chk("R3 ctrl reads zero", {32'd0, d}, 64'd0);
    rd(4'hC, d);
    chk("R3 unmapped reads zero", {32'd0, d}, 64'd0);

    // R6: end-of-interrupt with nothing pending
    pend = '0;
    step();
    wr(4'h8, 32'h1);
    repeat (4) step();
    chk("R6 armed idle", {63'd0, irq}, 64'd0);
    pend[183] = 1'b1;
    step();
    chk("R6 pulse on later pend", {63'd0, irq}, 64'd1);
    rd(4'h4, d);
    chk("R2 pin183 high word bit13", {32'd0, d}, 64'h2000);
    pend = '0; pend[127] = 1'b1; pend[128] = 1'b1;
    rd(4'h0, d);
    chk("R1 pin127 low bit31", {32'd0, d}, 64'h8000_0000);
    rd(4'h4, d);
    chk("R2 pin128 high bit0", {32'd0, d}, 64'h1);
    pend = '1;
    rd(4'h4, d);
    chk("R2 all pins high word", {32'd0, d}, 64'h3FFF);

    // random sparse patterns
    for (int it = 0; it < 200; it++) begin
      for (int p = 0; p < NPINS; p++) pend[p] = (($urandom % 16) == 0);
      e = exp_sum(pend);
      rd(4'h0, d);
      chk("R1 random low word", {32'd0, d}, {32'd0, e[31:0]});
      rd(4'h4, d);
      chk("R2 random high word", {32'd0, d}, {32'd0, e[63:32]});
      step();
    end

    done = 1'b1;
    summary_line();
    $finish;
  end

endmodule